// File: doc/BRIEF.md
# Branch Resolution and Next-PC Unit

This combinational unit sits beside the main ALU of a single-cycle integer core and computes the address of the next instruction. It takes the current PC, the 32-bit instruction word, the two source operand values and a two-bit PC-select class from the decoder. It has its own magnitude comparators and its own target adders, so a branch is resolved without using the ALU.

The comparators produce an equality flag, a signed less-than flag and an unsigned less-than flag. For a conditional branch, the funct3 field selects one of these flags and may invert it. Relative targets are formed from immediates that are reassembled from fixed instruction bit positions. A register-indirect jump adds a 12-bit immediate to the first operand and clears the lowest bit of the result. Writing the link address to the register file is handled elsewhere.

Top module: `bnpc_unit`

## Requirements
- R1: `cmp_eq_o` is 1 exactly when rs1 equals rs2. `cmp_lt_o` is 1 exactly when rs1 < rs2 as two's-complement numbers. `cmp_ltu_o` is 1 exactly when rs1 < rs2 as unsigned numbers. All three are valid for every `pc_sel_i` value.
- R2: With `pc_sel_i` = 2'b00 (sequential), `next_pc_o` = pc + 4.
- R3: With `pc_sel_i` = 2'b01 (branch) and the condition true, `next_pc_o` = pc + B-offset. The B-offset is the sign-extended 13-bit value {instr[31], instr[7], instr[30:25], instr[11:8], 0}.
- R4: With `pc_sel_i` = 2'b01 and the condition false, `next_pc_o` = pc + 4.
- R5: The branch condition is selected by instr[14:12]: 000 equal, 001 not equal, 100 signed less-than, 101 signed greater-or-equal, 110 unsigned less-than, 111 unsigned greater-or-equal. The codes 010 and 011 never take the branch.
- R6: With `pc_sel_i` = 2'b10 (direct jump), `next_pc_o` = pc + J-offset. The J-offset is the sign-extended 21-bit value with bit 20 = instr[31], bits 10:1 = instr[30:21], bit 11 = instr[20], bits 19:12 = instr[19:12] and bit 0 = 0.
- R7: With `pc_sel_i` = 2'b11 (register jump), `next_pc_o` = (rs1 + sign-extended instr[31:20]) with bit 0 forced to 0.
- R8: All target sums wrap modulo 2^32.
- R9: `branch_taken_o` is 1 only when `pc_sel_i` = 2'b01 and the selected condition is true.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc_i | input | 32 | Address of the current instruction |
| instr_i | input | 32 | Current instruction word |
| rs1_i | input | 32 | First source operand value |
| rs2_i | input | 32 | Second source operand value |
| pc_sel_i | input | 2 | PC class: 00 sequential, 01 branch, 10 direct jump, 11 register jump |
| next_pc_o | output | 32 | Next instruction address |
| cmp_eq_o | output | 1 | rs1 equals rs2 |
| cmp_lt_o | output | 1 | rs1 < rs2, signed |
| cmp_ltu_o | output | 1 | rs1 < rs2, unsigned |
| branch_taken_o | output | 1 | Conditional branch resolved as taken |

## Verification
The bench uses operand pairs whose sign bits differ, such as -1 against 1. In these cases the signed and unsigned orderings disagree, so a design that swapped the two comparators, or read the less-than result as unsigned, would pick the wrong flag and branch the wrong way. Every funct3 code is tried with both a true and a false condition, so a missing inversion shows up as a reversed decision. The reserved codes must stay not-taken. Branch and jump instructions are encoded from known signed offsets, negative ones included, so any misplaced immediate bit or lost sign extension moves the target to a wrong address. A register jump to an odd sum checks that bit 0 is cleared. Sums that carry past the top of the address space check that targets wrap.

// File: rtl/bnpc_pkg.sv
package bnpc_pkg;

    localparam int XLEN    = 32;
    localparam int ILEN    = 32;
    localparam int PC_STEP = ILEN / 8;

    typedef logic [XLEN-1:0] word_t;
    typedef logic [ILEN-1:0] insn_t;

    typedef enum logic [1:0] {
        PCS_SEQ    = 2'b00,
        PCS_BRANCH = 2'b01,
        PCS_JAL    = 2'b10,
        PCS_JALR   = 2'b11
    } pc_sel_e;

    typedef struct packed {
        logic eq;
        logic lt;
        logic ltu;
    } cmp_flags_t;

    typedef struct packed {
        word_t seq;
        word_t branch;
        word_t jal;
        word_t jalr;
    } targets_t;

    // Conditional-branch offset, bit 0 implicitly zero
    function automatic word_t imm_branch(input insn_t ir);
        logic [12:0] raw;
        raw = {ir[31], ir[7], ir[30:25], ir[11:8], 1'b0};
        return {{(XLEN-13){raw[12]}}, raw};
    endfunction

    // Direct-jump offset, bit 0 implicitly zero
    function automatic word_t imm_jump(input insn_t ir);
        logic [20:0] raw;
        raw = {ir[31], ir[19:12], ir[20], ir[30:21], 1'b0};
        return {{(XLEN-21){raw[20]}}, raw};
    endfunction

    // 12-bit immediate of the register-indirect jump
    function automatic word_t imm_itype(input insn_t ir);
        return {{(XLEN-12){ir[31]}}, ir[31:20]};
    endfunction

endpackage

// File: rtl/bnpc_compare.sv
module bnpc_compare
    import bnpc_pkg::*;
(
    input  word_t      a_i,
    input  word_t      b_i,
    output cmp_flags_t flags_o
);
    always_comb begin
        flags_o.eq  = (a_i == b_i);
        flags_o.lt  = ($signed(a_i) < $signed(b_i));
        flags_o.ltu = (a_i < b_i);
    end
endmodule

// File: rtl/bnpc_cond.sv
module bnpc_cond
    import bnpc_pkg::*;
(
    input  logic [2:0] funct3_i,
    input  cmp_flags_t flags_i,
    output logic       cond_o
);
    logic base;
    logic valid;

    always_comb begin
        valid = 1'b1;
        unique case (funct3_i[2:1])
            2'b00:   base = flags_i.eq;
            2'b10:   base = flags_i.lt;
            2'b11:   base = flags_i.ltu;
            default: begin
                base  = 1'b0;
                valid = 1'b0;
            end
        endcase
        cond_o = valid & (base ^ funct3_i[0]);
    end
endmodule

// File: rtl/bnpc_target.sv
module bnpc_target
    import bnpc_pkg::*;
(
    input  word_t    pc_i,
    input  insn_t    instr_i,
    input  word_t    rs1_i,
    output targets_t tgt_o
);
    word_t jalr_sum;

    always_comb begin
        jalr_sum      = rs1_i + imm_itype(instr_i);
        tgt_o.seq     = pc_i + word_t'(PC_STEP);
        tgt_o.branch  = pc_i + imm_branch(instr_i);
        tgt_o.jal     = pc_i + imm_jump(instr_i);
        tgt_o.jalr    = {jalr_sum[XLEN-1:1], 1'b0};
    end
endmodule

// File: rtl/bnpc_unit.sv
module bnpc_unit
    import bnpc_pkg::*;
(
    input  logic [31:0] pc_i,
    input  logic [31:0] instr_i,
    input  logic [31:0] rs1_i,
    input  logic [31:0] rs2_i,
    input  logic [1:0]  pc_sel_i,
    output logic [31:0] next_pc_o,
    output logic        cmp_eq_o,
    output logic        cmp_lt_o,
    output logic        cmp_ltu_o,
    output logic        branch_taken_o
);
    cmp_flags_t flags;
    targets_t   tgt;
    logic       cond;
    pc_sel_e    sel;

    assign sel = pc_sel_e'(pc_sel_i);

    bnpc_compare u_cmp (
        .a_i     (rs1_i),
        .b_i     (rs2_i),
        .flags_o (flags)
    );

    bnpc_cond u_cond (
        .funct3_i (instr_i[14:12]),
        .flags_i  (flags),
        .cond_o   (cond)
    );

    bnpc_target u_tgt (
        .pc_i    (pc_i),
        .instr_i (instr_i),
        .rs1_i   (rs1_i),
        .tgt_o   (tgt)
    );

    always_comb begin
        branch_taken_o = (sel == PCS_BRANCH) && cond;
        unique case (sel)
            PCS_BRANCH: next_pc_o = cond ? tgt.branch : tgt.seq;
            PCS_JAL:    next_pc_o = tgt.jal;
            PCS_JALR:   next_pc_o = tgt.jalr;
            default:    next_pc_o = tgt.seq;
        endcase
    end

    assign cmp_eq_o  = flags.eq;
    assign cmp_lt_o  = flags.lt;
    assign cmp_ltu_o = flags.ltu;
endmodule

// File: rtl/bnpc_checker.sv
module bnpc_checker (
    input logic [31:0] pc_i,
    input logic [31:0] instr_i,
    input logic [31:0] rs1_i,
    input logic [31:0] rs2_i,
    input logic [1:0]  pc_sel_i,
    input logic [31:0] next_pc_o,
    input logic        cmp_eq_o,
    input logic        cmp_lt_o,
    input logic        cmp_ltu_o,
    input logic        branch_taken_o
);
    logic known;
    assign known = !$isunknown({pc_i, instr_i, rs1_i, rs2_i, pc_sel_i});

    always_comb begin
        if (known) begin
            // R1: equality excludes both orderings
            a_r1_eq_excludes_lt: assert (!(cmp_eq_o && (cmp_lt_o || cmp_ltu_o)));
            // R1: with equal sign bits the two orderings agree
            a_r1_same_sign_agree: assert ((rs1_i[31] != rs2_i[31]) || (cmp_lt_o == cmp_ltu_o));
            // R2: sequential class steps by one word
            a_r2_seq_step: assert ((pc_sel_i != 2'b00) || (next_pc_o == pc_i + 32'd4));
            // R4: a branch that is not taken falls through
            a_r4_fallthrough: assert (!(pc_sel_i == 2'b01 && !branch_taken_o) || (next_pc_o == pc_i + 32'd4));
            // R5: reserved condition codes never branch
            a_r5_reserved_not_taken: assert (!(instr_i[14:13] == 2'b01 && branch_taken_o));
            // R7: register jump target is even
            a_r7_jalr_even: assert ((pc_sel_i != 2'b11) || (next_pc_o[0] == 1'b0));
            // R9: taken flag only for the branch class
            a_r9_taken_only_branch: assert (!branch_taken_o || (pc_sel_i == 2'b01));
            // R3 and R6: relative targets keep the halfword alignment of pc
            a_r3_rel_even: assert (!(pc_sel_i == 2'b01 || pc_sel_i == 2'b10) || (next_pc_o[0] == pc_i[0]));
        end
    end
endmodule

bind bnpc_unit bnpc_checker u_bnpc_checker (
    .pc_i           (pc_i),
    .instr_i        (instr_i),
    .rs1_i          (rs1_i),
    .rs2_i          (rs2_i),
    .pc_sel_i       (pc_sel_i),
    .next_pc_o      (next_pc_o),
    .cmp_eq_o       (cmp_eq_o),
    .cmp_lt_o       (cmp_lt_o),
    .cmp_ltu_o      (cmp_ltu_o),
    .branch_taken_o (branch_taken_o)
);

// File: tb/tb_bnpc_unit.sv
module tb_bnpc_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] pc_i, instr_i, rs1_i, rs2_i;
    logic [1:0]  pc_sel_i;
    logic [31:0] next_pc_o;
    logic        cmp_eq_o, cmp_lt_o, cmp_ltu_o, branch_taken_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2 clk = ~clk;

    bnpc_unit dut (
        .pc_i(pc_i), .instr_i(instr_i), .rs1_i(rs1_i), .rs2_i(rs2_i),
        .pc_sel_i(pc_sel_i), .next_pc_o(next_pc_o), .cmp_eq_o(cmp_eq_o),
        .cmp_lt_o(cmp_lt_o), .cmp_ltu_o(cmp_ltu_o), .branch_taken_o(branch_taken_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] enc_b(input logic [12:0] off, input logic [2:0] f3);
        return {off[12], off[10:5], 5'd2, 5'd1, f3, off[4:1], off[11], 7'b1100011};
    endfunction

    function automatic logic [31:0] enc_j(input logic [20:0] off);
        return {off[20], off[10:1], off[11], off[19:12], 5'd1, 7'b1101111};
    endfunction

    function automatic logic [31:0] enc_i(input logic [11:0] imm);
        return {imm, 5'd3, 3'b000, 5'd1, 7'b1100111};
    endfunction

    task automatic apply(input logic [31:0] pc, input logic [31:0] ir,
                         input logic [31:0] a, input logic [31:0] b, input logic [1:0] sel);
        @(negedge clk);
        pc_i = pc; instr_i = ir; rs1_i = a; rs2_i = b; pc_sel_i = sel;
        #1;
    endtask

    task automatic t_reset;
        apply(32'h0000_1000, 32'h0000_0013, 32'd0, 32'd0, 2'b00);
        chk("R2 idle step", next_pc_o, 32'h0000_1004);
        chk("R9 idle not taken", {31'd0, branch_taken_o}, 32'd0);
    endtask

    task automatic t_flags(input logic [31:0] a, input logic [31:0] b);
        apply(32'h100, 32'h13, a, b, 2'b00);
        chk("R1 eq", {31'd0, cmp_eq_o}, {31'd0, a == b});
        chk("R1 lt", {31'd0, cmp_lt_o}, {31'd0, $signed(a) < $signed(b)});
        chk("R1 ltu", {31'd0, cmp_ltu_o}, {31'd0, a < b});
    endtask

    task automatic t_branch(input logic [2:0] f3, input logic [31:0] a, input logic [31:0] b,
                            input logic [12:0] off);
        logic take;
        logic [31:0] pc;
        pc = 32'h0000_8000;
        case (f3)
            3'b000: take = (a == b);
            3'b001: take = (a != b);
            3'b100: take = ($signed(a) < $signed(b));
            3'b101: take = ($signed(a) >= $signed(b));
            3'b110: take = (a < b);
            3'b111: take = (a >= b);
            default: take = 1'b0;
        endcase
        apply(pc, enc_b(off, f3), a, b, 2'b01);
        chk(take ? "R3 R5 taken target" : "R4 R5 fallthrough", next_pc_o,
            take ? pc + {{19{off[12]}}, off} : pc + 32'd4);
        chk("R9 taken flag", {31'd0, branch_taken_o}, {31'd0, take});
    endtask

    task automatic t_jal(input logic [31:0] pc, input logic [20:0] off);
        apply(pc, enc_j(off), 32'h5, 32'h5, 2'b10);
        chk("R6 R8 jump target", next_pc_o, pc + {{11{off[20]}}, off});
        chk("R9 jump not branch", {31'd0, branch_taken_o}, 32'd0);
    endtask

    task automatic t_jalr(input logic [31:0] a, input logic [11:0] imm);
        logic [31:0] s;
        s = a + {{20{imm[11]}}, imm};
        s[0] = 1'b0;
        apply(32'h400, enc_i(imm), a, 32'd0, 2'b11);
        chk("R7 R8 reg jump", next_pc_o, s);
    endtask

    initial begin
        pc_i = 0; instr_i = 0; rs1_i = 0; rs2_i = 0; pc_sel_i = 0;
        repeat (2) @(posedge clk);
        rst = 1'b0;
        t_reset();
        t_flags(32'd7, 32'd7);
        t_flags(32'hFFFF_FFFF, 32'd1);
        t_flags(32'd1, 32'hFFFF_FFFF);
        t_flags(32'h8000_0000, 32'h7FFF_FFFF);
        t_flags(32'd3, 32'd9);
        for (int f = 0; f < 8; f++) begin
            t_branch(3'(f), 32'd5, 32'd5, 13'h010);
            t_branch(3'(f), 32'hFFFF_FFFF, 32'd1, 13'h1FE0);
            t_branch(3'(f), 32'd1, 32'hFFFF_FFFF, 13'h0FFE);
        end
        t_jal(32'h0000_2000, 21'h00_0800);
        t_jal(32'h0000_2000, 21'h1F_FFFC);
        t_jal(32'h0000_0000, 21'h10_0000);
        t_jal(32'hFFFF_FFF0, 21'h00_0020);
        t_jalr(32'h0000_1001, 12'h004);
        t_jalr(32'h0000_1000, 12'hFFF);
        t_jalr(32'hFFFF_FFFE, 12'h7FF);
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                checks++;
                failures++;
                $display("FAIL watchdog actual=running expected=done");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule